// File: doc/BRIEF.md
# Security lock erase controller

This block keeps a lock flag that guards secret state, and it runs the erase sequence that follows whenever that lock is released. A loader command can set the lock or clear it. A raw, active-high tamper line can also clear it once a glitch filter accepts the pulse. Either trigger starts the same cascade, and the cascade cannot be stopped. The cascade has four steps in a fixed order:

1. It wipes the key register and the vector memory in one cycle.
2. It sweeps the external RAM from address zero upward and writes zero to each word.
3. It gathers fresh bytes from a random source into a new key.
4. It returns to idle.

A tamper trigger also cuts the backup supply of the external bus for a fixed number of cycles. When the lock is set, or while the cascade runs, every loader request for external RAM is refused. On loader entry, the same byte gatherer builds a candidate key from the random source.

The controller is a four-state machine: `ST_IDLE`, `ST_WIPE`, `ST_SCRUB` and `ST_REKEY`. Its transitions are:
- `ST_IDLE` to `ST_WIPE` on a trigger, which is a clear command or a qualified tamper event.
- `ST_WIPE` to `ST_SCRUB` always, after one cycle.
- `ST_SCRUB` to `ST_REKEY` when the last scrub address has been issued.
- `ST_REKEY` to `ST_IDLE` when the last random byte has been taken in.

The random source, the cipher and the supply switch are outside this block. They appear only as ports.

Top module: `seclock_erase_ctrl`

## Requirements
- R1: After reset the lock is set (`lock_on`=1), `busy` is 0, and `key_wipe`, `vec_clear`, `scrub_we`, `rekey_req`, `key_load`, `cand_ready`, `supply_cut` and `ram_grant` are all 0.
- R2: A `lock_clr_cmd` pulse sampled in idle makes the next cycle show `key_wipe`=1, `vec_clear`=1, `lock_on`=0 and `busy`=1. Both wipe strobes last exactly one cycle.
- R3: `tamper_in` held high for at least FILT_W consecutive clock edges starts the same cascade as a clear command. Its wipe cycle is seen FILT_W+3 edges after the first edge at which the input was high. A pulse of fewer than FILT_W edges has no effect.
- R4: A tamper-started cascade drives `supply_cut` high for CUT_LEN cycles, beginning with the wipe cycle. A command-started cascade never drives it.
- R5: `ram_grant` equals `ram_req` only while the lock is clear and the block is idle. Otherwise it is 0.
- R6: The cycle after the wipe cycle begins SCRUB_DEPTH consecutive cycles with `scrub_we`=1, and `scrub_addr` counts 0, 1, … SCRUB_DEPTH-1. The data written is zero.
- R7: After the sweep, `rekey_req` stays high until KEY_BYTES bytes have been taken from `rng_byte` on cycles with `rng_valid`=1. The first byte taken lands in the top byte of `key_word`. `key_load` pulses for one cycle as the key becomes valid, and `busy` drops in the following cycle.
- R8: `busy` stays high without a gap from the wipe cycle through the `key_load` cycle.
- R9: While the cascade runs, `lock_set_cmd` and `lock_clr_cmd` are ignored. The sweep neither restarts nor stalls, and `lock_on` is 0 when the block returns to idle.
- R10: A `loader_enter` pulse in idle gathers KEY_BYTES valid bytes as a candidate key. `cand_ready` rises together with the last byte's capture, and `key_load` stays 0. A cascade clears `cand_ready` from its first scrub cycle.
- R11: A `lock_set_cmd` pulse sampled in idle makes `lock_on`=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_set_cmd | input | 1 | Loader strobe that sets the lock |
| lock_clr_cmd | input | 1 | Loader strobe that clears the lock and starts the erase |
| tamper_in | input | 1 | Raw active-high tamper line, asynchronous |
| loader_enter | input | 1 | Strobe marking loader entry; starts candidate key gathering |
| ram_req | input | 1 | Loader request for an external RAM access |
| rng_valid | input | 1 | A random byte is present on rng_byte |
| rng_byte | input | 8 | Random byte from the external source |
| lock_on | output | 1 | Lock flag state |
| busy | output | 1 | Erase cascade in progress |
| key_wipe | output | 1 | One-cycle wipe strobe for the key register |
| vec_clear | output | 1 | One-cycle clear strobe for the vector memory |
| ram_grant | output | 1 | Loader RAM access allowed |
| scrub_we | output | 1 | Zero-write strobe for the RAM sweep |
| scrub_addr | output | $clog2(SCRUB_DEPTH) | Address of the current zero write |
| rekey_req | output | 1 | Request for random bytes for the new key |
| key_load | output | 1 | One-cycle strobe: key_word holds the new key |
| key_word | output | 8*KEY_BYTES | Gathered key bytes, first byte at the top |
| cand_ready | output | 1 | Candidate key from loader entry is complete |
| supply_cut | output | 1 | Backup supply of the external bus removed |

## Verification
Each result has a fixed due time after its stimulus:
- A clear command shows its wipe cycle one edge after it is sampled.
- A tamper pulse is due FILT_W+3 edges after it first goes high, because it passes two synchronizer stages, the width counter and an event register before reaching the state register.
- Each scrub address appears one edge after the previous one.
- `key_load` and `cand_ready` rise at the edge that captures the last byte, and `busy` falls one edge later.

The bench drives inputs on falling edges and reads outputs at the following falling edge. It counts edges to the due cycle and checks the outputs at that exact cycle, and it also checks that nothing changed before it. The tamper sweep covers pulse widths from 1 to FILT_W+2 edges, so it checks both sides of the filter threshold.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WIPE  = 2'd1,
        ST_SCRUB = 2'd2,
        ST_REKEY = 2'd3
    } lk_state_t;

endpackage

// File: rtl/tamper_filter.sv
module tamper_filter #(
    parameter int FILT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic evt
);
    localparam int CW = $clog2(FILT_W + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(FILT_W);
    localparam logic [CW-1:0] CNT_HIT = CW'(FILT_W - 1);

    logic          sync1_q;
    logic          sync2_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            run_q   <= '0;
            evt     <= 1'b0;
        end else begin
            sync1_q <= raw_in;
            sync2_q <= sync1_q;
            evt     <= 1'b0;
            if (!sync2_q) begin
                run_q <= '0;
            end else if (run_q != CNT_MAX) begin
                run_q <= run_q + 1'b1;
                if (run_q == CNT_HIT) begin
                    evt <= 1'b1;
                end
            end
        end
    end

    // R3
    tamper_single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

endmodule

// File: rtl/rng_gather.sv
module rng_gather #(
    parameter int NBYTES = 8,
    localparam int WW = 8 * NBYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    output logic [WW-1:0] word,
    output logic          done,
    output logic          full
);
    localparam int NW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [NW-1:0] LAST_IDX = NW'(NBYTES - 1);

    logic          collecting_q;
    logic [NW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collecting_q <= 1'b0;
            idx_q        <= '0;
            word         <= '0;
            done         <= 1'b0;
            full         <= 1'b0;
        end else if (abort) begin
            collecting_q <= 1'b0;
            idx_q        <= '0;
            done         <= 1'b0;
            full         <= 1'b0;
        end else if (start) begin
            collecting_q <= 1'b1;
            idx_q        <= '0;
            done         <= 1'b0;
            full         <= 1'b0;
        end else begin
            done <= 1'b0;
            if (collecting_q && byte_vld) begin
                word <= {word[WW-9:0], byte_in};
                if (idx_q == LAST_IDX) begin
                    collecting_q <= 1'b0;
                    idx_q        <= '0;
                    done         <= 1'b1;
                    full         <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R7
    gather_done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(byte_vld));

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq #(
    parameter int DEPTH = 32768,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] ADDR_END = AW'(DEPTH - 1);

    assign last = (addr == ADDR_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (en) begin
            addr <= last ? '0 : addr + 1'b1;
        end
    end

    // R6
    scrub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !last) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/seclock_erase_ctrl.sv
module seclock_erase_ctrl
    import seclock_pkg::*;
#(
    parameter int FILT_W      = 4,
    parameter int CUT_LEN     = 16,
    parameter int SCRUB_DEPTH = 32768,
    parameter int KEY_BYTES   = 8,
    localparam int AW = $clog2(SCRUB_DEPTH),
    localparam int KW = 8 * KEY_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_set_cmd,
    input  logic          lock_clr_cmd,
    input  logic          tamper_in,
    input  logic          loader_enter,
    input  logic          ram_req,
    input  logic          rng_valid,
    input  logic [7:0]    rng_byte,
    output logic          lock_on,
    output logic          busy,
    output logic          key_wipe,
    output logic          vec_clear,
    output logic          ram_grant,
    output logic          scrub_we,
    output logic [AW-1:0] scrub_addr,
    output logic          rekey_req,
    output logic          key_load,
    output logic [KW-1:0] key_word,
    output logic          cand_ready,
    output logic          supply_cut
);
    localparam int CTW = $clog2(CUT_LEN + 1);
    localparam logic [CTW-1:0] CUT_INIT = CTW'(CUT_LEN);

    lk_state_t      state_q, state_d;
    logic           tamper_evt;
    logic           trigger;
    logic           scrub_last;
    logic           gather_start, gather_abort, gather_done, gather_full;
    logic           cand_mode_q;
    logic [CTW-1:0] cut_q;
    logic           in_idle;

    tamper_filter #(.FILT_W(FILT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (tamper_in),
        .evt    (tamper_evt)
    );

    scrub_seq #(.DEPTH(SCRUB_DEPTH)) u_scrub (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_WIPE),
        .en    (state_q == ST_SCRUB),
        .addr  (scrub_addr),
        .last  (scrub_last)
    );

    rng_gather #(.NBYTES(KEY_BYTES)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (gather_start),
        .abort    (gather_abort),
        .byte_vld (rng_valid),
        .byte_in  (rng_byte),
        .word     (key_word),
        .done     (gather_done),
        .full     (gather_full)
    );

    assign in_idle      = (state_q == ST_IDLE);
    assign trigger      = lock_clr_cmd || tamper_evt;
    assign gather_abort = (state_q == ST_WIPE);
    assign gather_start = (in_idle && loader_enter && !trigger) ||
                          (state_q == ST_SCRUB && scrub_last);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trigger)     state_d = ST_WIPE;
            ST_WIPE:                   state_d = ST_SCRUB;
            ST_SCRUB: if (scrub_last)  state_d = ST_REKEY;
            ST_REKEY: if (gather_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state, lock flag, supply cut timer, candidate mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lock_on     <= 1'b1;
            cut_q       <= '0;
            cand_mode_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_idle) begin
                if (trigger)           lock_on <= 1'b0;
                else if (lock_set_cmd) lock_on <= 1'b1;
            end
            if (in_idle && tamper_evt) cut_q <= CUT_INIT;
            else if (cut_q != '0)      cut_q <= cut_q - 1'b1;
            if (state_q == ST_WIPE)                           cand_mode_q <= 1'b0;
            else if (in_idle && loader_enter && !trigger)     cand_mode_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        key_wipe   = 1'b0;
        vec_clear  = 1'b0;
        scrub_we   = 1'b0;
        rekey_req  = 1'b0;
        key_load   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WIPE:  begin key_wipe = 1'b1; vec_clear = 1'b1; end
            ST_SCRUB: scrub_we = 1'b1;
            ST_REKEY: begin rekey_req = 1'b1; key_load = gather_done; end
            default:  ;
        endcase
        busy       = !in_idle;
        ram_grant  = ram_req && !lock_on && in_idle;
        supply_cut = (cut_q != '0);
        cand_ready = gather_full && cand_mode_q;
    end

    // R2
    unlock_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && lock_clr_cmd) |=> (key_wipe && vec_clear && !lock_on && busy));

    // R5
    grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_grant |-> (!lock_on && !busy));

    // R9
    cascade_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !lock_on);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !key_load) |=> busy);

    // R7
    rekey_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> !busy);

    // R4
    cut_only_tamper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_cut) |-> $past(tamper_evt));

endmodule

// File: tb/sim_seclock_erase_ctrl.sv
module sim_seclock_erase_ctrl;
    localparam int FW  = 4;
    localparam int CUT = 6;
    localparam int DEP = 16;
    localparam int NB  = 8;
    localparam int AW  = $clog2(DEP);

    logic clk = 1'b0;
    logic rst_n;
    logic lock_set_cmd, lock_clr_cmd, tamper_in, loader_enter, ram_req, rng_valid;
    logic [7:0] rng_byte;
    logic lock_on, busy, key_wipe, vec_clear, ram_grant, scrub_we, rekey_req;
    logic key_load, cand_ready, supply_cut;
    logic [AW-1:0] scrub_addr;
    logic [8*NB-1:0] key_word;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    seclock_erase_ctrl #(.FILT_W(FW), .CUT_LEN(CUT), .SCRUB_DEPTH(DEP), .KEY_BYTES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .lock_set_cmd(lock_set_cmd), .lock_clr_cmd(lock_clr_cmd),
        .tamper_in(tamper_in), .loader_enter(loader_enter), .ram_req(ram_req),
        .rng_valid(rng_valid), .rng_byte(rng_byte), .lock_on(lock_on), .busy(busy),
        .key_wipe(key_wipe), .vec_clear(vec_clear), .ram_grant(ram_grant),
        .scrub_we(scrub_we), .scrub_addr(scrub_addr), .rekey_req(rekey_req),
        .key_load(key_load), .key_word(key_word), .cand_ready(cand_ready),
        .supply_cut(supply_cut)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // feeds NB bytes; optional gap cycle; returns expected word
    task automatic feed_bytes(input logic [7:0] seed, input bit gap, output logic [63:0] exp);
        exp = '0;
        for (int i = 0; i < NB; i++) begin
            if (gap && i == 3) begin
                rng_valid = 1'b0;
                rng_byte  = 8'hEE;
                step();
            end
            rng_valid = 1'b1;
            rng_byte  = seed ^ 8'(i * 37 + 5);
            exp = {exp[55:0], rng_byte};
            step();
        end
        rng_valid = 1'b0;
        rng_byte  = 8'h00;
    endtask

    // entered at the observation right after the wipe edge
    task automatic run_cascade(input bit exp_cut, input bit inject, input logic [7:0] seed);
        logic [63:0] exp;
        ram_req = 1'b1;
        chk(key_wipe == 1'b1, "R2 key_wipe in wipe cycle", 64'(key_wipe), 64'd1);
        chk(vec_clear == 1'b1, "R2 vec_clear in wipe cycle", 64'(vec_clear), 64'd1);
        chk(lock_on == 1'b0, "R2 lock cleared in wipe cycle", 64'(lock_on), 64'd0);
        chk(busy == 1'b1, "R8 busy in wipe cycle", 64'(busy), 64'd1);
        chk(supply_cut == exp_cut, "R4 supply_cut in wipe cycle", 64'(supply_cut), 64'(exp_cut));
        step();
        for (int k = 0; k < DEP; k++) begin
            chk(scrub_we == 1'b1, "R6 scrub_we", 64'(scrub_we), 64'd1);
            chk(scrub_addr == AW'(k), "R6 scrub_addr", 64'(scrub_addr), 64'(k));
            chk(key_wipe == 1'b0 && vec_clear == 1'b0, "R2 wipe strobes one cycle", 64'({key_wipe, vec_clear}), 64'd0);
            chk(busy == 1'b1, "R8 busy during scrub", 64'(busy), 64'd1);
            chk(ram_grant == 1'b0, "R5 no grant during cascade", 64'(ram_grant), 64'd0);
            chk(cand_ready == 1'b0, "R10 cand_ready cleared by cascade", 64'(cand_ready), 64'd0);
            chk(supply_cut == (exp_cut && (k + 1 < CUT)), "R4 supply_cut window",
                64'(supply_cut), 64'(exp_cut && (k + 1 < CUT)));
            if (inject) begin
                lock_set_cmd = (k == 2);
                lock_clr_cmd = (k == 3);
                loader_enter = (k == 5);
            end
            step();
        end
        lock_set_cmd = 1'b0; lock_clr_cmd = 1'b0; loader_enter = 1'b0;
        chk(rekey_req == 1'b1, "R7 rekey_req after sweep", 64'(rekey_req), 64'd1);
        chk(scrub_we == 1'b0, "R6 sweep ends after DEPTH writes", 64'(scrub_we), 64'd0);
        chk(key_load == 1'b0, "R7 no key_load before bytes", 64'(key_load), 64'd0);
        feed_bytes(seed, 1'b0, exp);
        chk(key_load == 1'b1, "R7 key_load pulse", 64'(key_load), 64'd1);
        chk(key_word == exp, "R7 new key value", key_word, exp);
        chk(busy == 1'b1, "R8 busy in key_load cycle", 64'(busy), 64'd1);
        step();
        chk(busy == 1'b0, "R7 busy drops after key_load", 64'(busy), 64'd0);
        chk(key_load == 1'b0, "R7 key_load one cycle", 64'(key_load), 64'd0);
        chk(lock_on == 1'b0, "R9 lock stays clear despite commands", 64'(lock_on), 64'd0);
        chk(rekey_req == 1'b0, "R7 rekey_req dropped", 64'(rekey_req), 64'd0);
        ram_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] exp;
        rst_n = 1'b0;
        lock_set_cmd = 0; lock_clr_cmd = 0; tamper_in = 0; loader_enter = 0;
        ram_req = 0; rng_valid = 0; rng_byte = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(lock_on == 1'b1, "R1 lock set after reset", 64'(lock_on), 64'd1);
        chk({busy, key_wipe, vec_clear, scrub_we, rekey_req, key_load, cand_ready, supply_cut} == 8'd0,
            "R1 outputs idle after reset",
            64'({busy, key_wipe, vec_clear, scrub_we, rekey_req, key_load, cand_ready, supply_cut}), 64'd0);
        ram_req = 1'b1;
        #1;
        chk(ram_grant == 1'b0, "R5 locked refuses RAM", 64'(ram_grant), 64'd0);
        ram_req = 1'b0;

        // command-started cascade with commands injected mid-run (R2, R9)
        lock_clr_cmd = 1'b1;
        step();
        lock_clr_cmd = 1'b0;
        run_cascade(1'b0, 1'b1, 8'h3C);

        ram_req = 1'b1;
        #1;
        chk(ram_grant == 1'b1, "R5 unlocked idle grants RAM", 64'(ram_grant), 64'd1);
        ram_req = 1'b0;

        // R11 set lock
        step();
        lock_set_cmd = 1'b1;
        step();
        lock_set_cmd = 1'b0;
        chk(lock_on == 1'b1, "R11 lock set by command", 64'(lock_on), 64'd1);
        ram_req = 1'b1;
        #1;
        chk(ram_grant == 1'b0, "R5 relocked refuses RAM", 64'(ram_grant), 64'd0);
        ram_req = 1'b0;

        // R10 candidate key on loader entry
        step();
        loader_enter = 1'b1;
        step();
        loader_enter = 1'b0;
        chk(cand_ready == 1'b0, "R10 cand_ready low while gathering", 64'(cand_ready), 64'd0);
        feed_bytes(8'hA5, 1'b1, exp);
        chk(cand_ready == 1'b1, "R10 cand_ready after last byte", 64'(cand_ready), 64'd1);
        chk(key_word == exp, "R10 candidate key value", key_word, exp);
        chk(key_load == 1'b0, "R10 no key_load for candidate", 64'(key_load), 64'd0);
        chk(busy == 1'b0 && lock_on == 1'b1, "R10 capture leaves lock and idle",
            64'({busy, lock_on}), 64'd1);

        // R3 tamper width sweep
        for (int w = 1; w <= FW + 2; w++) begin
            step();
            for (int i = 0; i < FW + 2; i++) begin
                tamper_in = (i < w);
                step();
                chk(busy == 1'b0, "R3 no trigger before filter latency", 64'(busy), 64'd0);
            end
            tamper_in = ((FW + 2) < w);
            step();
            tamper_in = 1'b0;
            if (w >= FW) begin
                chk(busy == 1'b1, "R3 qualified tamper starts cascade", 64'(busy), 64'd1);
                run_cascade(1'b1, 1'b0, 8'(w * 17));
            end else begin
                chk(busy == 1'b0 && key_wipe == 1'b0, "R3 short tamper ignored",
                    64'({busy, key_wipe}), 64'd0);
                chk(supply_cut == 1'b0, "R4 short tamper no cut", 64'(supply_cut), 64'd0);
                chk(lock_on == 1'b1, "R3 short tamper keeps lock", 64'(lock_on), 64'd1);
            end
            repeat (4) begin
                step();
                chk(busy == 1'b0, "R3 no late trigger", 64'(busy), 64'd0);
            end
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule